// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the per-channel datapath of a four-channel, ISA-style DMA controller. It keeps a base and a current copy of a 16-bit address register, a 16-bit count register, a low page register and a high page register. From these it forms the 32-bit physical address of each transfer cycle. After every accepted transfer strobe it steps the address forward by one transfer unit and counts the transfer count down.

When the count steps past zero, the block raises terminal count for one cycle. If auto-initialise is enabled, it then restores its current registers from the base copies. Otherwise it masks itself until the host unmasks it again. The host-side register decoder, request and acknowledge handshakes, and arbitration belong to the surrounding controller.

The `WORD_CH` parameter selects the channel type. With `WORD_CH = 0` the channel moves bytes and each page spans 64K. With `WORD_CH = 1` the channel moves 16-bit words: the address register counts words, page bit 0 is ignored, and each page spans 128K.

Top module: `dma_ch_engine`

## Requirements
- R1: After reset, phys_addr_o = 0, count_o = 0, tc_o = 0, mask_o = 1 and mode_o = 0.
- R2: A write to the address or count register loads both the base and the current copy. A later auto-initialise restores the written values even after the current copy has stepped. Each page write also loads both copies of its page register.
- R3: On a byte channel, phys_addr_o = {high page[7:0], page[7:0], address[15:0]}.
- R4: On a word channel, phys_addr_o = {high page[7:0], page[7:1], address[15:0], 1'b0}, and page bit 0 has no effect on the address.
- R5: A step that is accepted increments the address register by one and decrements count_o by one. A step is accepted when step_i is high, mask_o is 0, and no register write happens in the same cycle.
- R6: If the high page has not been written since the last address or page write, the address register wraps from 0xFFFF to 0x0000 and the page bits of phys_addr_o stay unchanged.
- R7: After a high page write, a carry out of the address register propagates into the page and high-page fields. On word channels, page bit 0 is kept.
- R8: An accepted step while count_o = 0x0000 raises tc_o for exactly the following cycle. The count register holds the number of transfers minus one.
- R9: With auto-initialise off, terminal count sets mask_o to 1 and count_o reads 0xFFFF. Steps are then ignored until unmask_i clears the mask.
- R10: With auto-initialise on, terminal count reloads the address, page, high page and count from their base copies, and mask_o stays 0.
- R11: mode_wr_i latches wdata_i[7:0] into mode_o. Bits 3:2 = 01 drive dev_to_mem_o, bits 3:2 = 10 drive mem_to_dev_o, and bit 4 drives autoinit_o.
- R12: An address write cancels the carry enable set by an earlier high page write. The high page must therefore be written last to allow carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_wr_i | input | 1 | Load address register from wdata_i |
| cnt_wr_i | input | 1 | Load count register from wdata_i |
| page_wr_i | input | 1 | Load page register from wdata_i[7:0] |
| hipage_wr_i | input | 1 | Load high page from wdata_i[7:0] and enable carry |
| mode_wr_i | input | 1 | Load mode from wdata_i[7:0] |
| wdata_i | input | 16 | Write data |
| unmask_i | input | 1 | Clear the channel mask |
| step_i | input | 1 | One transfer cycle completed |
| phys_addr_o | output | 32 | Physical address of the current transfer |
| count_o | output | 16 | Current count (remaining transfers minus one) |
| tc_o | output | 1 | Terminal count pulse |
| mask_o | output | 1 | Channel masked |
| mode_o | output | 8 | Latched mode value |
| dev_to_mem_o | output | 1 | Device-to-memory direction |
| mem_to_dev_o | output | 1 | Memory-to-device direction |
| autoinit_o | output | 1 | Auto-initialise enabled |

## Verification
The bench builds two copies of the block side by side, one with WORD_CH = 0 and one with WORD_CH = 1, and feeds both from the same register writes and steps. Every step therefore yields a byte address and a word address from the same register state. This exposes the one-bit shift and the ignored page bit 0 on word channels. It also exposes how a page carry differs when page bit 0 is set. The stimulus crosses the 0xFFFF address edge both with and without carry enable, and runs terminal count in both the masking mode and the auto-initialise mode.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;
  localparam int ADDR_W = 16;
  localparam int PAGE_W = 8;
  localparam int HI_W   = 8;
  localparam int MODE_W = 8;
  localparam int PHYS_W = HI_W + PAGE_W + ADDR_W;

  // mode field positions
  localparam int DIR_LSB  = 2;
  localparam int AUTO_BIT = 4;
  localparam logic [1:0] DIR_D2M = 2'b01;
  localparam logic [1:0] DIR_M2D = 2'b10;
endpackage

// File: rtl/dma_ch_addr.sv
module dma_ch_addr
  import dma_ch_pkg::*;
#(
  parameter bit WORD_CH = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_wr_i,
  input  logic              page_wr_i,
  input  logic              hipage_wr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              adv_i,
  input  logic              reload_i,
  output logic [PHYS_W-1:0] phys_o
);
  logic [ADDR_W-1:0] base_a_q, cur_a_q, nxt_a;
  logic [PAGE_W-1:0] base_pg_q, cur_pg_q, nxt_pg;
  logic [HI_W-1:0]   base_hi_q, cur_hi_q, nxt_hi;
  logic              carry_en_q;

  generate
    if (WORD_CH) begin : g_word
      localparam int LIN_W = PHYS_W - 1;
      logic [LIN_W-1:0] lin, nxt;
      assign lin    = {cur_hi_q, cur_pg_q[PAGE_W-1:1], cur_a_q};
      assign nxt    = lin + LIN_W'(1);
      assign nxt_a  = nxt[ADDR_W-1:0];
      assign nxt_pg = {nxt[ADDR_W+PAGE_W-2:ADDR_W], cur_pg_q[0]};
      assign nxt_hi = nxt[LIN_W-1:ADDR_W+PAGE_W-1];
      assign phys_o = {lin, 1'b0};
    end else begin : g_byte
      logic [PHYS_W-1:0] lin, nxt;
      assign lin    = {cur_hi_q, cur_pg_q, cur_a_q};
      assign nxt    = lin + PHYS_W'(1);
      assign nxt_a  = nxt[ADDR_W-1:0];
      assign nxt_pg = nxt[ADDR_W+PAGE_W-1:ADDR_W];
      assign nxt_hi = nxt[PHYS_W-1:ADDR_W+PAGE_W];
      assign phys_o = lin;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_a_q   <= '0;
      cur_a_q    <= '0;
      base_pg_q  <= '0;
      cur_pg_q   <= '0;
      base_hi_q  <= '0;
      cur_hi_q   <= '0;
      carry_en_q <= 1'b0;
    end else begin
      if (addr_wr_i) begin
        base_a_q   <= wdata_i;
        cur_a_q    <= wdata_i;
        carry_en_q <= 1'b0;
      end
      if (page_wr_i) begin
        base_pg_q  <= wdata_i[PAGE_W-1:0];
        cur_pg_q   <= wdata_i[PAGE_W-1:0];
        carry_en_q <= 1'b0;
      end
      if (hipage_wr_i) begin
        base_hi_q  <= wdata_i[HI_W-1:0];
        cur_hi_q   <= wdata_i[HI_W-1:0];
        carry_en_q <= 1'b1;
      end
      if (reload_i) begin
        cur_a_q  <= base_a_q;
        cur_pg_q <= base_pg_q;
        cur_hi_q <= base_hi_q;
      end else if (adv_i) begin
        cur_a_q <= nxt_a;
        if (carry_en_q) begin
          cur_pg_q <= nxt_pg;
          cur_hi_q <= nxt_hi;
        end
      end
    end
  end
endmodule

// File: rtl/dma_ch_count.sv
module dma_ch_count
  import dma_ch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_wr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              dec_i,
  input  logic              reload_i,
  output logic [ADDR_W-1:0] cnt_o,
  output logic              at_zero_o
);
  logic [ADDR_W-1:0] base_q, cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (cnt_wr_i) begin
      base_q <= wdata_i;
      cur_q  <= wdata_i;
    end else if (reload_i) begin
      cur_q <= base_q;
    end else if (dec_i) begin
      cur_q <= cur_q - ADDR_W'(1);
    end
  end

  assign cnt_o     = cur_q;
  assign at_zero_o = (cur_q == '0);
endmodule

// File: rtl/dma_ch_ctrl.sv
module dma_ch_ctrl
  import dma_ch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_wr_i,
  input  logic [MODE_W-1:0] mode_val_i,
  input  logic              unmask_i,
  input  logic              step_i,
  input  logic              wr_any_i,
  input  logic              at_zero_i,
  output logic              adv_o,
  output logic              reload_o,
  output logic              tc_o,
  output logic              mask_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              auto_o
);
  logic [MODE_W-1:0] mode_q;
  logic              mask_q, tc_q, hit_tc;

  assign auto_o   = mode_q[AUTO_BIT];
  assign adv_o    = step_i & ~mask_q & ~wr_any_i;
  assign hit_tc   = adv_o & at_zero_i;
  assign reload_o = hit_tc & auto_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      mask_q <= 1'b1;
      tc_q   <= 1'b0;
    end else begin
      if (mode_wr_i) mode_q <= mode_val_i;
      tc_q <= hit_tc;
      if (hit_tc && !auto_o) mask_q <= 1'b1;
      else if (unmask_i)     mask_q <= 1'b0;
    end
  end

  assign tc_o   = tc_q;
  assign mask_o = mask_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/dma_ch_engine.sv
module dma_ch_engine
  import dma_ch_pkg::*;
#(
  parameter bit WORD_CH = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_wr_i,
  input  logic              cnt_wr_i,
  input  logic              page_wr_i,
  input  logic              hipage_wr_i,
  input  logic              mode_wr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              unmask_i,
  input  logic              step_i,
  output logic [PHYS_W-1:0] phys_addr_o,
  output logic [ADDR_W-1:0] count_o,
  output logic              tc_o,
  output logic              mask_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              dev_to_mem_o,
  output logic              mem_to_dev_o,
  output logic              autoinit_o
);
  logic wr_any, adv, reload, at_zero;
  logic [1:0] dir;

  // any register write cancels a step in the same cycle
  assign wr_any = addr_wr_i | cnt_wr_i | page_wr_i | hipage_wr_i | mode_wr_i;

  dma_ch_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_wr_i  (mode_wr_i),
    .mode_val_i (wdata_i[MODE_W-1:0]),
    .unmask_i   (unmask_i),
    .step_i     (step_i),
    .wr_any_i   (wr_any),
    .at_zero_i  (at_zero),
    .adv_o      (adv),
    .reload_o   (reload),
    .tc_o       (tc_o),
    .mask_o     (mask_o),
    .mode_o     (mode_o),
    .auto_o     (autoinit_o)
  );

  dma_ch_addr #(.WORD_CH(WORD_CH)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_wr_i   (addr_wr_i),
    .page_wr_i   (page_wr_i),
    .hipage_wr_i (hipage_wr_i),
    .wdata_i     (wdata_i),
    .adv_i       (adv),
    .reload_i    (reload),
    .phys_o      (phys_addr_o)
  );

  dma_ch_count u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_wr_i  (cnt_wr_i),
    .wdata_i   (wdata_i),
    .dec_i     (adv),
    .reload_i  (reload),
    .cnt_o     (count_o),
    .at_zero_o (at_zero)
  );

  assign dir          = mode_o[DIR_LSB+1:DIR_LSB];
  assign dev_to_mem_o = (dir == DIR_D2M);
  assign mem_to_dev_o = (dir == DIR_M2D);
endmodule

// File: rtl/dma_ch_engine_chk.sv
module dma_ch_engine_chk
  import dma_ch_pkg::*;
#(
  parameter bit WORD_CH = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              addr_wr_i,
  input logic              cnt_wr_i,
  input logic              page_wr_i,
  input logic              hipage_wr_i,
  input logic              mode_wr_i,
  input logic              step_i,
  input logic [PHYS_W-1:0] phys_addr_o,
  input logic [ADDR_W-1:0] count_o,
  input logic              tc_o,
  input logic              mask_o,
  input logic              autoinit_o
);
  localparam int PG_LO = ADDR_W + (WORD_CH ? 1 : 0);

  logic wr_any, go, hi_seen_q;
  assign wr_any = addr_wr_i | cnt_wr_i | page_wr_i | hipage_wr_i | mode_wr_i;
  assign go     = step_i & ~mask_o & ~wr_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      hi_seen_q <= 1'b0;
    else if (hipage_wr_i)             hi_seen_q <= 1'b1;
    else if (addr_wr_i || page_wr_i)  hi_seen_q <= 1'b0;
  end

  p_count_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && count_o != '0) |=> (count_o == $past(count_o) - ADDR_W'(1)));

  p_tc_onset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && count_o == '0) |=> tc_o);

  p_page_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && !hi_seen_q && !(autoinit_o && count_o == '0))
      |=> (phys_addr_o[PHYS_W-1:PG_LO] == $past(phys_addr_o[PHYS_W-1:PG_LO])));

  p_masked_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o && !wr_any) |=> ($stable(phys_addr_o) && $stable(count_o)));

  p_tc_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !autoinit_o && !$past(mode_wr_i)) |-> mask_o);

  p_reload_live_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && autoinit_o && !$past(mode_wr_i)) |-> !mask_o);
endmodule

bind dma_ch_engine dma_ch_engine_chk #(.WORD_CH(WORD_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_wr_i   (addr_wr_i),
  .cnt_wr_i    (cnt_wr_i),
  .page_wr_i   (page_wr_i),
  .hipage_wr_i (hipage_wr_i),
  .mode_wr_i   (mode_wr_i),
  .step_i      (step_i),
  .phys_addr_o (phys_addr_o),
  .count_o     (count_o),
  .tc_o        (tc_o),
  .mask_o      (mask_o),
  .autoinit_o  (autoinit_o)
);

// File: tb/dma_ch_engine_bench.sv
module dma_ch_engine_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic addr_wr = 0, cnt_wr = 0, page_wr = 0, hipage_wr = 0, mode_wr = 0;
  logic unmask = 0, step = 0;
  logic [15:0] wdata = '0;
  logic [31:0] phys_b, phys_w;
  logic [15:0] cnt_b, cnt_w;
  logic tc_b, tc_w, mask_b, mask_w, d2m, m2d, auto_b;
  logic d2m_w, m2d_w, auto_w;
  logic [7:0] mode_b, mode_w;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  dma_ch_engine #(.WORD_CH(1'b0)) u_dma_ch_engine (
    .clk_i(clk), .rst_ni(rst_ni), .addr_wr_i(addr_wr), .cnt_wr_i(cnt_wr),
    .page_wr_i(page_wr), .hipage_wr_i(hipage_wr), .mode_wr_i(mode_wr),
    .wdata_i(wdata), .unmask_i(unmask), .step_i(step),
    .phys_addr_o(phys_b), .count_o(cnt_b), .tc_o(tc_b), .mask_o(mask_b),
    .mode_o(mode_b), .dev_to_mem_o(d2m), .mem_to_dev_o(m2d), .autoinit_o(auto_b));

  dma_ch_engine #(.WORD_CH(1'b1)) u_dma_ch_engine_w (
    .clk_i(clk), .rst_ni(rst_ni), .addr_wr_i(addr_wr), .cnt_wr_i(cnt_wr),
    .page_wr_i(page_wr), .hipage_wr_i(hipage_wr), .mode_wr_i(mode_wr),
    .wdata_i(wdata), .unmask_i(unmask), .step_i(step),
    .phys_addr_o(phys_w), .count_o(cnt_w), .tc_o(tc_w), .mask_o(mask_w),
    .mode_o(mode_w), .dev_to_mem_o(d2m_w), .mem_to_dev_o(m2d_w), .autoinit_o(auto_w));

  // op: 0 addr, 1 count, 2 page, 3 high page, 4 mode, 5 unmask, 6 step
  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] val;
    logic [31:0] pb;
    logic [31:0] pw;
    logic [15:0] cnt;
    logic        mask;
    logic        tc;
    logic [2:0]  fl;   // {autoinit, mem_to_dev, dev_to_mem}
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{3'd4, 16'h0044, 32'h00000000, 32'h00000000, 16'h0000, 1'b1, 1'b0, 3'b001}, // R11
    '{3'd0, 16'hFFFE, 32'h0000FFFE, 32'h0001FFFC, 16'h0000, 1'b1, 1'b0, 3'b001}, // R3 R4
    '{3'd2, 16'h0013, 32'h0013FFFE, 32'h0013FFFC, 16'h0000, 1'b1, 1'b0, 3'b001},
    '{3'd1, 16'h0002, 32'h0013FFFE, 32'h0013FFFC, 16'h0002, 1'b1, 1'b0, 3'b001},
    '{3'd5, 16'h0000, 32'h0013FFFE, 32'h0013FFFC, 16'h0002, 1'b0, 1'b0, 3'b001},
    '{3'd6, 16'h0000, 32'h0013FFFF, 32'h0013FFFE, 16'h0001, 1'b0, 1'b0, 3'b001}, // R5
    '{3'd6, 16'h0000, 32'h00130000, 32'h00120000, 16'h0000, 1'b0, 1'b0, 3'b001}, // R6 wrap
    '{3'd6, 16'h0000, 32'h00130001, 32'h00120002, 16'hFFFF, 1'b1, 1'b1, 3'b001}, // R8 R9
    '{3'd6, 16'h0000, 32'h00130001, 32'h00120002, 16'hFFFF, 1'b1, 1'b0, 3'b001}, // R9 ignored
    '{3'd0, 16'hFFFF, 32'h0013FFFF, 32'h0013FFFE, 16'hFFFF, 1'b1, 1'b0, 3'b001},
    '{3'd3, 16'h00A5, 32'hA513FFFF, 32'hA513FFFE, 16'hFFFF, 1'b1, 1'b0, 3'b001},
    '{3'd1, 16'h0001, 32'hA513FFFF, 32'hA513FFFE, 16'h0001, 1'b1, 1'b0, 3'b001},
    '{3'd5, 16'h0000, 32'hA513FFFF, 32'hA513FFFE, 16'h0001, 1'b0, 1'b0, 3'b001},
    '{3'd6, 16'h0000, 32'hA5140000, 32'hA5140000, 16'h0000, 1'b0, 1'b0, 3'b001}, // R7 carry
    '{3'd6, 16'h0000, 32'hA5140001, 32'hA5140002, 16'hFFFF, 1'b1, 1'b1, 3'b001},
    '{3'd4, 16'h0058, 32'hA5140001, 32'hA5140002, 16'hFFFF, 1'b1, 1'b0, 3'b110}, // R11
    '{3'd0, 16'h1000, 32'hA5141000, 32'hA5142000, 16'hFFFF, 1'b1, 1'b0, 3'b110}, // R7 page bit0 kept
    '{3'd1, 16'h0000, 32'hA5141000, 32'hA5142000, 16'h0000, 1'b1, 1'b0, 3'b110},
    '{3'd5, 16'h0000, 32'hA5141000, 32'hA5142000, 16'h0000, 1'b0, 1'b0, 3'b110},
    '{3'd6, 16'h0000, 32'hA5131000, 32'hA5122000, 16'h0000, 1'b0, 1'b1, 3'b110}, // R10 R2 reload
    '{3'd6, 16'h0000, 32'hA5131000, 32'hA5122000, 16'h0000, 1'b0, 1'b1, 3'b110},
    '{3'd6, 16'h0000, 32'hA5131000, 32'hA5122000, 16'h0000, 1'b0, 1'b1, 3'b110}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [15:0] val);
    @(negedge clk);
    wdata     = val;
    addr_wr   = (op == 3'd0);
    cnt_wr    = (op == 3'd1);
    page_wr   = (op == 3'd2);
    hipage_wr = (op == 3'd3);
    mode_wr   = (op == 3'd4);
    unmask    = (op == 3'd5);
    step      = (op == 3'd6);
    @(negedge clk);
    {addr_wr, cnt_wr, page_wr, hipage_wr, mode_wr, unmask, step} = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 phys byte", phys_b, 32'h0);
    chk("R1 phys word", phys_w, 32'h0);
    chk("R1 count", {16'h0, cnt_b}, 32'h0);
    chk("R1 mask", {31'h0, mask_b}, 32'h1);
    chk("R1 tc", {31'h0, tc_b}, 32'h0);
    chk("R1 mode", {24'h0, mode_b}, 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_op(TBL[i].op, TBL[i].val);
      chk($sformatf("R3 byte phys #%0d", i), phys_b, TBL[i].pb);
      chk($sformatf("R4 word phys #%0d", i), phys_w, TBL[i].pw);
      chk($sformatf("R5 count #%0d", i), {16'h0, cnt_b}, {16'h0, TBL[i].cnt});
      chk($sformatf("R5 word count #%0d", i), {16'h0, cnt_w}, {16'h0, TBL[i].cnt});
      chk($sformatf("R9 mask #%0d", i), {31'h0, mask_b}, {31'h0, TBL[i].mask});
      chk($sformatf("R8 tc #%0d", i), {31'h0, tc_b}, {31'h0, TBL[i].tc});
      chk($sformatf("R11 mode flags #%0d", i), {29'h0, auto_b, m2d, d2m},
          {29'h0, TBL[i].fl});
    end
    chk("R11 mode byte", {24'h0, mode_b}, 32'h58);

    // R12: high page written before address write gives no carry
    run_op(3'd1, 16'h0005);
    run_op(3'd3, 16'h0077);
    chk("R12 high page byte", phys_b, 32'h77131000);
    chk("R12 high page word", phys_w, 32'h77122000);
    run_op(3'd0, 16'hFFFF);
    run_op(3'd6, 16'h0000);
    chk("R12 no carry byte", phys_b, 32'h77130000);
    chk("R12 no carry word", phys_w, 32'h77120000);
    chk("R12 count", {16'h0, cnt_b}, 32'h4);

    // R5: write in the same cycle as a step cancels the step
    @(negedge clk);
    step = 1'b1; page_wr = 1'b1; wdata = 16'h0022;
    @(negedge clk);
    {step, page_wr} = '0;
    chk("R5 step dropped on write count", {16'h0, cnt_b}, 32'h4);
    chk("R5 step dropped on write addr", phys_b, 32'h77220000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule